// File: doc/BRIEF.md
# Endpoint Control Register File

This block holds the per-endpoint control and status words of a USB device function, plus the device-address register. Software reads and writes the words through a single-cycle register port. The packet engine signals completed receptions, completed transmissions and SETUP packets through per-endpoint event strobes. Each endpoint word packs three kinds of field:

- plain fields that load the written value;
- handshake-status and data-toggle fields that flip wherever a 1 is written;
- completion flags that clear wherever a 0 is written.

Because of these rules, software can change a single field without a read-modify-write race against the hardware.

The block also reports which half of a double buffer each side owns. In double-buffered bulk mode, the software pointer of one direction is the data-toggle bit of the other direction. It also reports which endpoints have a completion pending, and the lowest-numbered one among them.

Endpoint word layout (bit positions):

| Bits | Field |
|------|-------|
| [15] | RX-complete flag |
| [14] | RX toggle |
| [13:12] | RX handshake |
| [11] | TX-complete flag |
| [10] | TX toggle |
| [9:8] | TX handshake |
| [7] | setup flag |
| [6] | kind |
| [5:4] | type |
| [3:0] | endpoint number |

Handshake encoding is 00 disabled, 01 stall, 10 NAK, 11 valid. Type encoding is 00 bulk, 01 control, 10 isochronous, 11 interrupt.

Register index `0..NUM_EP-1` selects an endpoint word. Index `NUM_EP` selects the device-address register, which reads as {enable at bit 7, address at bits 6:0}.

Top module: `ep_ctrl_regfile`

## Requirements
- R1: After reset, every endpoint word reads 0x0000 and the device-address register reads 0x0080 (enable=1, address 0).
- R2: Each handshake and toggle bit (bits 14,13,12,10,9,8) flips when written 1 and holds when written 0.
- R3: The completion flags (bits 15 and 11) clear when written 0 and hold when written 1.
- R4: The endpoint number, type and kind (bits 6:0 except 7) take the written value.
- R5: The setup flag (bit 7) ignores writes. An RX event loads it with the setup strobe. A TX event leaves it unchanged.
- R6: An RX event sets bit 15 and flips bit 14. It also forces RX handshake to NAK (10), unless the endpoint is double buffered (type 00 bulk with kind=1).
- R7: A TX event sets bit 11 and flips bit 10. It also forces TX handshake to NAK (10), unless the endpoint is double buffered.
- R8: When a write of 0 to a completion flag coincides with the event that sets it, the flag ends set.
- R9: Per endpoint:
  - `tx_hw_half` is the TX toggle and `tx_sw_half` is the RX toggle.
  - `rx_hw_half` is the RX toggle and `rx_sw_half` is the TX toggle.
  - `dbl_buf` marks bulk+kind.
- R10: `ep_pend[i]` is high when endpoint i has either completion flag set. `pend_any` is their OR. `pend_idx` is the lowest pending endpoint, or 0 when none is pending.
- R11: A write to index `NUM_EP` loads the device-address register from data bits 7:0. Higher data bits are ignored.
- R12: Reads of an unmapped index return 0. Writes to an unmapped index change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Register index for writes |
| wr_data | input | 16 | Write data |
| rd_idx | input | IDX_W | Register index for reads |
| rd_data | output | 16 | Read data (combinational) |
| rx_done_ev | input | NUM_EP | Reception-complete strobes |
| tx_done_ev | input | NUM_EP | Transmission-complete strobes |
| setup_ev | input | NUM_EP | Marks the coinciding reception as SETUP |
| ep_pend | output | NUM_EP | Completion pending per endpoint |
| pend_any | output | 1 | Some endpoint is pending |
| pend_idx | output | PEND_W | Lowest pending endpoint |
| dbl_buf | output | NUM_EP | Endpoint is double-buffered bulk |
| tx_hw_half | output | NUM_EP | TX half owned by hardware |
| tx_sw_half | output | NUM_EP | TX half owned by software |
| rx_hw_half | output | NUM_EP | RX half owned by hardware |
| rx_sw_half | output | NUM_EP | RX half owned by software |

## Verification
The bench builds the block with NUM_EP=4. This makes the device-address register sit at index 4 and leaves indices 5 to 7 unmapped, so writes to dead indices can be checked against live words. The small endpoint count also puts the highest endpoint within a short sequence, which exercises the priority encoder with two and then one pending sources. One endpoint is configured as control and one as double-buffered bulk. This contrasts the forced-NAK rule with the free-running toggle and the swapped software buffer pointer.

// File: rtl/ep_regs_pkg.sv
package ep_regs_pkg;

  typedef enum logic [1:0] {
    HS_OFF   = 2'b00,
    HS_STALL = 2'b01,
    HS_NAK   = 2'b10,
    HS_VALID = 2'b11
  } hs_t;

  typedef enum logic [1:0] {
    EPT_BULK = 2'b00,
    EPT_CTRL = 2'b01,
    EPT_ISO  = 2'b10,
    EPT_INTR = 2'b11
  } ept_t;

  typedef struct packed {
    logic       rx_done;
    logic       rx_tog;
    logic [1:0] rx_hs;
    logic       tx_done;
    logic       tx_tog;
    logic [1:0] tx_hs;
    logic       setup;
    logic       kind;
    logic [1:0] ep_type;
    logic [3:0] ep_num;
  } ep_word_t;

  localparam int WORD_W = $bits(ep_word_t);

  // Merge a software write into the current word by field kind.
  function automatic ep_word_t merge_write(ep_word_t cur, ep_word_t w);
    ep_word_t r;
    r         = cur;
    r.ep_num  = w.ep_num;
    r.ep_type = w.ep_type;
    r.kind    = w.kind;
    r.rx_hs   = cur.rx_hs ^ w.rx_hs;
    r.tx_hs   = cur.tx_hs ^ w.tx_hs;
    r.rx_tog  = cur.rx_tog ^ w.rx_tog;
    r.tx_tog  = cur.tx_tog ^ w.tx_tog;
    r.rx_done = cur.rx_done & w.rx_done;
    r.tx_done = cur.tx_done & w.tx_done;
    return r;
  endfunction

  function automatic logic is_double(ep_word_t r);
    return (r.ep_type == EPT_BULK) && r.kind;
  endfunction

endpackage

// File: rtl/ep_slot.sv
module ep_slot
  import ep_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rx_ev,
  input  logic              tx_ev,
  input  logic              setup_in,
  output logic [WORD_W-1:0] word_q,
  output logic              pend,
  output logic              dbl_mode
);

  ep_word_t q, after_sw, nxt, wd;

  assign wd       = ep_word_t'(wr_data);
  assign dbl_mode = is_double(q);

  always_comb begin
    after_sw = wr_hit ? merge_write(q, wd) : q;
    nxt      = after_sw;
    if (rx_ev) begin
      nxt.rx_done = 1'b1;
      nxt.rx_tog  = ~after_sw.rx_tog;
      nxt.setup   = setup_in;
      if (!dbl_mode) nxt.rx_hs = HS_NAK;
    end
    if (tx_ev) begin
      nxt.tx_done = 1'b1;
      nxt.tx_tog  = ~after_sw.tx_tog;
      if (!dbl_mode) nxt.tx_hs = HS_NAK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign word_q = q;
  assign pend   = q.rx_done | q.tx_done;

  AST_RX_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ev |=> q.rx_done); // R6
  AST_DONE_W0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !wd.rx_done && !rx_ev) |=> !q.rx_done); // R3
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !wd.tx_done && tx_ev) |=> q.tx_done); // R8
  AST_TOG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ev && !(wr_hit && wd.rx_tog)) |=> $stable(q.rx_tog)); // R2
  AST_SINGLE_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ev && !dbl_mode) |=> (q.tx_hs == HS_NAK)); // R7
  AST_SETUP_RO: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ev |=> $stable(q.setup)); // R5

endmodule

// File: rtl/pend_prio.sv
module pend_prio #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend_vec,
  output logic         any,
  output logic [W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_vec[i]) idx = W'(i);
    end
  end

  assign any = |pend_vec;

  AST_IDX_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> pend_vec[idx]); // R10
  AST_NO_LOWER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((pend_vec & ((N'(1) << idx) - N'(1))) == '0)); // R10

endmodule

// File: rtl/dev_addr_reg.sv
module dev_addr_reg #(
  parameter logic [7:0] RESET_VAL = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [7:0] wr_byte,
  output logic [7:0] dev_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      dev_q <= RESET_VAL;
    else if (wr_hit) dev_q <= wr_byte;
  end

  AST_DEV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(dev_q)); // R11

endmodule

// File: rtl/ep_ctrl_regfile.sv
module ep_ctrl_regfile
  import ep_regs_pkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int IDX_W  = $clog2(NUM_EP) + 1,
  localparam int PEND_W = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  input  logic [NUM_EP-1:0] rx_done_ev,
  input  logic [NUM_EP-1:0] tx_done_ev,
  input  logic [NUM_EP-1:0] setup_ev,
  output logic [NUM_EP-1:0] ep_pend,
  output logic              pend_any,
  output logic [PEND_W-1:0] pend_idx,
  output logic [NUM_EP-1:0] dbl_buf,
  output logic [NUM_EP-1:0] tx_hw_half,
  output logic [NUM_EP-1:0] tx_sw_half,
  output logic [NUM_EP-1:0] rx_hw_half,
  output logic [NUM_EP-1:0] rx_sw_half
);

  localparam logic [IDX_W-1:0] DEV_IDX = IDX_W'(NUM_EP);

  logic [WORD_W-1:0] slot_q [NUM_EP];
  logic [7:0]        dev_q;
  logic              dev_hit;

  assign dev_hit = wr_en && (wr_idx == DEV_IDX);

  for (genvar g = 0; g < NUM_EP; g++) begin : g_slot
    ep_word_t w;
    ep_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_en && (wr_idx == IDX_W'(g))),
      .wr_data  (wr_data),
      .rx_ev    (rx_done_ev[g]),
      .tx_ev    (tx_done_ev[g]),
      .setup_in (setup_ev[g]),
      .word_q   (slot_q[g]),
      .pend     (ep_pend[g]),
      .dbl_mode (dbl_buf[g])
    );
    assign w             = ep_word_t'(slot_q[g]);
    assign tx_hw_half[g] = w.tx_tog;
    assign tx_sw_half[g] = w.rx_tog;
    assign rx_hw_half[g] = w.rx_tog;
    assign rx_sw_half[g] = w.tx_tog;
  end

  dev_addr_reg u_dev (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (dev_hit),
    .wr_byte (wr_data[7:0]),
    .dev_q   (dev_q)
  );

  pend_prio #(.N(NUM_EP), .W(PEND_W)) u_prio (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_vec (ep_pend),
    .any      (pend_any),
    .idx      (pend_idx)
  );

  always_comb begin
    rd_data = '0;
    if (rd_idx == DEV_IDX) rd_data = WORD_W'(dev_q);
    for (int i = 0; i < NUM_EP; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = slot_q[i];
    end
  end

  AST_DEAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx > DEV_IDX) |-> (rd_data == '0)); // R12

endmodule

// File: tb/test_ep_ctrl_regfile.sv
module test_ep_ctrl_regfile;
  localparam int NUM_EP = 4;
  localparam int IDX_W  = 3;
  localparam int PEND_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0, rd_idx = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [NUM_EP-1:0] rx_ev = '0, tx_ev = '0, su_ev = '0;
  logic [NUM_EP-1:0] ep_pend, dbl_buf, tx_hw_half, tx_sw_half, rx_hw_half, rx_sw_half;
  logic pend_any;
  logic [PEND_W-1:0] pend_idx;

  always #10 clk = ~clk;

  ep_ctrl_regfile #(.NUM_EP(NUM_EP)) i_ep_ctrl_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .rx_done_ev(rx_ev), .tx_done_ev(tx_ev),
    .setup_ev(su_ev), .ep_pend(ep_pend), .pend_any(pend_any), .pend_idx(pend_idx),
    .dbl_buf(dbl_buf), .tx_hw_half(tx_hw_half), .tx_sw_half(tx_sw_half),
    .rx_hw_half(rx_hw_half), .rx_sw_half(rx_sw_half)
  );

  typedef struct {
    int          kind;
    int          idx;
    logic [15:0] val;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Monitor: pops one expected item per falling edge and compares.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      logic [15:0] act;
      e = exp_q.pop_front();
      case (e.kind)
        0: act = rd_data;
        1: act = 16'({pend_any, pend_idx, ep_pend});
        default: act = 16'({dbl_buf[e.idx], tx_hw_half[e.idx], tx_sw_half[e.idx],
                            rx_hw_half[e.idx], rx_sw_half[e.idx]});
      endcase
      n_chk++;
      if (act !== e.val) begin
        n_bad++;
        $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h", e.tag, e.kind, e.idx, act, e.val);
      end
    end
  end

  task automatic expect_item(int kind, int idx, logic [15:0] val, string tag);
    exp_t e;
    if (kind == 0) rd_idx = IDX_W'(idx);
    e.kind = kind; e.idx = idx; e.val = val; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk); #1;
  endtask

  task automatic cyc(bit we, int idx, logic [15:0] d,
                     logic [NUM_EP-1:0] rx, logic [NUM_EP-1:0] tx, logic [NUM_EP-1:0] su);
    @(posedge clk); #1;
    wr_en = we; wr_idx = IDX_W'(idx); wr_data = d; rx_ev = rx; tx_ev = tx; su_ev = su;
    @(posedge clk); #1;
    wr_en = 0; rx_ev = '0; tx_ev = '0; su_ev = '0;
  endtask

  task automatic wr(int idx, logic [15:0] d);
    cyc(1, idx, d, '0, '0, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_item(0, 0, 16'h0000, "R1 ep0 reset");
    expect_item(0, 4, 16'h0080, "R1 dev addr reset");
    expect_item(1, 0, 16'h0000, "R1 nothing pending");

    wr(1, 16'h0055);
    expect_item(0, 1, 16'h0055, "R4 plain fields");
    wr(1, 16'h00D5);
    expect_item(0, 1, 16'h0055, "R5 setup ignores write");

    wr(1, 16'h3255);
    expect_item(0, 1, 16'h3255, "R2 hs toggle from zero");
    wr(1, 16'h1155);
    expect_item(0, 1, 16'h2355, "R2 hs toggle low bits");
    wr(1, 16'h4455);
    expect_item(0, 1, 16'h6755, "R2 data toggles flip");
    wr(1, 16'h0055);
    expect_item(0, 1, 16'h6755, "R2 zeros hold");
    wr(1, 16'h1055);
    expect_item(0, 1, 16'h7755, "R2 rx hs to valid");

    cyc(0, 0, 16'h0000, 4'b0010, 4'b0000, 4'b0010);
    expect_item(0, 1, 16'hA7D5, "R6 rx event single buffered, R5 setup set");
    expect_item(1, 0, 16'h0052, "R10 ep1 pending");

    wr(1, 16'h8855);
    expect_item(0, 1, 16'hA7D5, "R3 write one holds flags");
    wr(1, 16'h0055);
    expect_item(0, 1, 16'h27D5, "R3 write zero clears");
    expect_item(1, 0, 16'h0000, "R10 cleared");

    cyc(0, 0, 16'h0000, 4'b0000, 4'b0010, 4'b0000);
    expect_item(0, 1, 16'h2AD5, "R7 tx event, R5 setup kept");

    cyc(1, 1, 16'h0055, 4'b0000, 4'b0010, 4'b0000);
    expect_item(0, 1, 16'h2ED5, "R8 event beats clear");

    wr(2, 16'h0042);
    wr(2, 16'h3042);
    expect_item(0, 2, 16'h3042, "R4 bulk double config");
    cyc(0, 0, 16'h0000, 4'b0100, 4'b0000, 4'b0000);
    expect_item(0, 2, 16'hF042, "R6 double buffered keeps valid");
    expect_item(2, 2, 16'h0016, "R9 halves after rx");
    wr(2, 16'h8442);
    expect_item(0, 2, 16'hF442, "R9 sw rx pointer flip");
    expect_item(2, 2, 16'h001F, "R9 halves after sw flip");

    expect_item(1, 0, 16'h0056, "R10 two pending lowest ep1");
    wr(1, 16'h0055);
    expect_item(0, 1, 16'h26D5, "R3 tx flag cleared");
    expect_item(1, 0, 16'h0064, "R10 lowest now ep2");
    cyc(0, 0, 16'h0000, 4'b0000, 4'b1000, 4'b0000);
    expect_item(1, 0, 16'h006C, "R10 ep3 added, lowest ep2");

    wr(4, 16'h0023);
    expect_item(0, 4, 16'h0023, "R11 dev addr write");
    wr(4, 16'hFFA5);
    expect_item(0, 4, 16'h00A5, "R11 high bits ignored");

    expect_item(0, 5, 16'h0000, "R12 unmapped read");
    wr(5, 16'hFFFF);
    expect_item(0, 0, 16'h0000, "R12 dead write leaves ep0");
    expect_item(0, 4, 16'h00A5, "R12 dead write leaves dev");

    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule